// File: doc/BRIEF.md
# Dual-Rail Minterm-Synthesis Function Node

This block is one self-timed logic node of configurable fan-in K (2 to 4) that computes any K-input Boolean function. Each input and the output travel as a rail pair. Under the pair encoding {true rail, false rail}:

- 10 is logic 1.
- 01 is logic 0.
- 00 is the empty (spacer) state.
- 11 is forbidden.

The node contains one hold-state coincidence element per input combination, 2^K in all. Element m takes the true rail of input j when bit j of m is 1, and the false rail otherwise. The element rises when all of its rails are high and falls when all are low; in every other case it keeps its value. An OR of the elements whose combination maps to 1 in the truth-table parameter drives the output true rail. An OR of the rest drives the output false rail. The output pair is itself the completion signal, so no separate detector exists.

The hold state is modelled as registers updated on `clk`. Inputs follow a four-phase cycle: all become valid, the output becomes valid, all return to spacer, then the output returns to spacer. There is no valid/ready handshake and no back-pressure. The rail pairs themselves are the flow control, and the surrounding network must wait for the output code before it changes the inputs. A sticky monitor flags a forbidden input code, or an input that goes directly from one valid value to the other between two clock samples.

Top module: `dims_node`

## Requirements
- R1: With every input valid, the output becomes 10 when TRUTH[idx] is 1 and 01 when TRUTH[idx] is 0. The index idx has bit j equal to the value of input j, so input 0 is the least significant bit.
- R2: While the error flag is low, the output pair is never 11.
- R3: During and right after reset (`rst_n` low), the output is 00 and `err` is 0.
- R4: While the output is 00, it stays 00 until every input pair is valid. A partly valid input set leaves it at 00.
- R5: While the output is valid, it keeps its value until every input pair is back at 00.
- R6: The output turns valid after the first rising `clk` edge at which all inputs are sampled valid. It returns to 00 after the first rising edge at which all inputs are sampled at 00.
- R7: An input pair sampled as 11 sets `err` at that rising edge.
- R8: An input pair that is sampled valid on one rising edge and at the opposite valid value on the next sets `err`.
- R9: Once set, `err` stays high until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock for the hold-state elements and the monitor |
| rst_n | input | 1 | Active-low reset; clears all elements and the error flag |
| in_t | input | K | True rails of the inputs, bit j is input j |
| in_f | input | K | False rails of the inputs, bit j is input j |
| out_t | output | 1 | Output true rail |
| out_f | output | 1 | Output false rail |
| err | output | 1 | Sticky protocol-violation flag |

## Verification
A coincidence element stuck high or low shows up at the ports within one cycle. The output either fails to turn valid for its combination, or it stays valid after the inputs return to spacer, which is visible at the next negative-edge sample. A wrong OR-plane mapping gives an output value of the wrong polarity for one specific combination, so every combination is driven in a directed pass. A weak hold, such as an element that clears on a partial spacer, is caught by the checks made at every skewed intermediate step.

// File: rtl/dims_pkg.sv
package dims_pkg;

  typedef enum logic [1:0] {
    RC_EMPTY = 2'b00,
    RC_ZERO  = 2'b01,
    RC_ONE   = 2'b10,
    RC_BAD   = 2'b11
  } rail_code_e;

  function automatic rail_code_e pack_rails(input logic t, input logic f);
    return rail_code_e'({t, f});
  endfunction

  function automatic logic is_valid_code(input rail_code_e c);
    return (c == RC_ZERO) || (c == RC_ONE);
  endfunction

endpackage

// File: rtl/dims_celem.sv
module dims_celem #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] a,
  output logic         q
);

  logic q_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q_r <= 1'b0;
    else if (&a)     q_r <= 1'b1;
    else if (~|a)    q_r <= 1'b0;
  end

  assign q = q_r;

  // R4
  celem_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(q_r) |-> $past(&a));

  // R5
  celem_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(q_r) |-> $past(~|a));

endmodule

// File: rtl/dims_or_plane.sv
module dims_or_plane #(
  parameter int M = 8,
  parameter logic [M-1:0] TT = '0
) (
  input  logic [M-1:0] mt,
  output logic         y_t,
  output logic         y_f
);

  logic [M-1:0] on_set;
  logic [M-1:0] off_set;

  for (genvar m = 0; m < M; m++) begin : g_split
    if (TT[m]) begin : g_on
      assign on_set[m]  = mt[m];
      assign off_set[m] = 1'b0;
    end else begin : g_off
      assign on_set[m]  = 1'b0;
      assign off_set[m] = mt[m];
    end
  end

  assign y_t = |on_set;
  assign y_f = |off_set;

endmodule

// File: rtl/dims_rail_monitor.sv
module dims_rail_monitor
  import dims_pkg::*;
#(
  parameter int K = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [K-1:0] in_t,
  input  logic [K-1:0] in_f,
  output logic         err
);

  logic [K-1:0] prev_t, prev_f;
  logic [K-1:0] bad_now;
  logic [K-1:0] jump_now;
  logic         err_q;

  for (genvar j = 0; j < K; j++) begin : g_lane
    rail_code_e cur_c, old_c;
    assign cur_c       = pack_rails(in_t[j], in_f[j]);
    assign old_c       = pack_rails(prev_t[j], prev_f[j]);
    assign bad_now[j]  = (cur_c == RC_BAD);
    assign jump_now[j] = is_valid_code(cur_c) && is_valid_code(old_c) && (cur_c != old_c);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_t <= '0;
      prev_f <= '0;
      err_q  <= 1'b0;
    end else begin
      prev_t <= in_t;
      prev_f <= in_f;
      if ((|bad_now) || (|jump_now)) err_q <= 1'b1;
    end
  end

  assign err = err_q;

  // R7
  bad_code_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(in_t & in_f)) |=> err_q);

  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(err_q) |-> err_q);

endmodule

// File: rtl/dims_node.sv
module dims_node #(
  parameter int K = 3,
  parameter logic [(1<<K)-1:0] TRUTH = 8'hB2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [K-1:0] in_t,
  input  logic [K-1:0] in_f,
  output logic         out_t,
  output logic         out_f,
  output logic         err
);

  localparam int M = 1 << K;

  logic [M-1:0] mt_hold;

  for (genvar m = 0; m < M; m++) begin : g_minterm
    logic [K-1:0] sel;
    for (genvar j = 0; j < K; j++) begin : g_pick
      if (((m >> j) & 1) == 1) begin : g_t
        assign sel[j] = in_t[j];
      end else begin : g_f
        assign sel[j] = in_f[j];
      end
    end
    dims_celem #(.W(K)) u_c (
      .clk  (clk),
      .rst_n(rst_n),
      .a    (sel),
      .q    (mt_hold[m])
    );
  end

  dims_or_plane #(.M(M), .TT(TRUTH)) u_or (
    .mt (mt_hold),
    .y_t(out_t),
    .y_f(out_f)
  );

  dims_rail_monitor #(.K(K)) u_mon (
    .clk  (clk),
    .rst_n(rst_n),
    .in_t (in_t),
    .in_f (in_f),
    .err  (err)
  );

  // R2
  no_both_high_chk: assert property (@(posedge clk) disable iff (!rst_n || err)
    !(out_t && out_f));

  // R4
  leave_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(out_t | out_f) && (out_t | out_f)) |-> $past(&(in_t | in_f)));

  // R5
  return_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(out_t | out_f) && !(out_t | out_f)) |-> $past(~|(in_t | in_f)));

  // R3
  always_comb begin
    if (!rst_n) reset_state_chk: assert (!out_t && !out_f);
  end

endmodule

// File: tb/tb_dims_node.sv
module tb_dims_node;

  localparam int K = 3;
  localparam int M = 1 << K;
  localparam logic [M-1:0] TT = 8'hB2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [K-1:0] in_t = '0;
  logic [K-1:0] in_f = '0;
  logic out_t, out_f, err;
  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  dims_node #(.K(K), .TRUTH(TT)) dut (
    .clk(clk), .rst_n(rst_n), .in_t(in_t), .in_f(in_f),
    .out_t(out_t), .out_f(out_f), .err(err)
  );

  task automatic chk(input bit ok, input string tag, input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [1:0] exp_out(input logic [K-1:0] v);
    return TT[v] ? 2'b10 : 2'b01;
  endfunction

  // R2 continuous monitor
  always @(negedge clk) begin
    if (rst_n && !err && !finished)
      chk(!(out_t && out_f), "R2 no 11 output", {1'b0, out_t, out_f}, 3'b000);
  end

  task automatic wave(input logic [K-1:0] v);
    int ord[K];
    for (int i = 0; i < K; i++) ord[i] = i;
    for (int i = K - 1; i > 0; i--) begin
      int r = $urandom % (i + 1);
      int t = ord[i]; ord[i] = ord[r]; ord[r] = t;
    end
    for (int i = 0; i < K; i++) begin
      if (v[ord[i]]) in_t[ord[i]] = 1'b1; else in_f[ord[i]] = 1'b1;
      if (i < K - 1) begin
        int w = $urandom % 3;
        repeat (w) @(negedge clk);
        if (w > 0) chk(!out_t && !out_f, "R4 partial valid keeps spacer", {1'b0, out_t, out_f}, 3'b000);
      end
    end
    @(negedge clk);
    chk({out_t, out_f} == exp_out(v), "R1/R6 output value", {v[0], out_t, out_f}, {v[0], exp_out(v)});
    for (int i = K - 1; i > 0; i--) begin
      int r = $urandom % (i + 1);
      int t = ord[i]; ord[i] = ord[r]; ord[r] = t;
    end
    for (int i = 0; i < K; i++) begin
      in_t[ord[i]] = 1'b0; in_f[ord[i]] = 1'b0;
      if (i < K - 1) begin
        int w = $urandom % 3;
        repeat (w) @(negedge clk);
        if (w > 0) chk({out_t, out_f} == exp_out(v), "R5 partial spacer holds output", {1'b0, out_t, out_f}, {1'b0, exp_out(v)});
      end
    end
    @(negedge clk);
    chk(!out_t && !out_f, "R6 return to spacer", {1'b0, out_t, out_f}, 3'b000);
    repeat ($urandom % 2) @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'h1D2E3F));
    repeat (3) @(negedge clk);
    chk(!out_t && !out_f && !err, "R3 reset state", {err, out_t, out_f}, 3'b000);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!out_t && !out_f && !err, "R3 after reset", {err, out_t, out_f}, 3'b000);
    // R1 every combination, checks indexing with input 0 as LSB
    for (int m = 0; m < M; m++) wave(m[K-1:0]);
    for (int n = 0; n < 200; n++) wave(K'($urandom));
    chk(!err, "R8 no error under legal traffic", {err, 2'b00}, 3'b000);

    // R8 direct valid-to-valid jump on input 0
    in_f = '1;
    @(negedge clk);
    chk({out_t, out_f} == exp_out(3'b000), "R1 all zero", {1'b0, out_t, out_f}, {1'b0, exp_out(3'b000)});
    in_f[0] = 1'b0; in_t[0] = 1'b1;
    @(negedge clk);
    chk(err, "R8 jump sets err", {err, 2'b00}, 3'b100);
    in_t = '0; in_f = '0;
    repeat (2) @(negedge clk);
    chk(err, "R9 err stays after spacer", {err, 2'b00}, 3'b100);

    rst_n = 1'b0;
    @(negedge clk);
    chk(!err && !out_t && !out_f, "R3 R9 reset clears", {err, out_t, out_f}, 3'b000);
    rst_n = 1'b1;
    @(negedge clk);

    // R7 forbidden input code
    in_t[1] = 1'b1; in_f[1] = 1'b1;
    @(negedge clk);
    chk(err, "R7 11 input sets err", {err, 2'b00}, 3'b100);
    in_t = '0; in_f = '0;
    repeat (3) @(negedge clk);
    chk(err, "R9 err sticky", {err, 2'b00}, 3'b100);
    chk(!out_t && !out_f, "R4 no output from bad code", {1'b0, out_t, out_f}, 3'b000);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule